// File: doc/BRIEF.md
# Iterative Integer Divider with Zero-Byte Skip

A sequential divider for a processor execution unit. It produces one 64-bit quotient or remainder per request. A request is a single-cycle start pulse that carries the dividend, the divisor and three mode flags:

- signed or unsigned arithmetic,
- full-width or half-width (32-bit) operands,
- quotient or remainder as the returned result.

The unit runs a restoring shift-and-subtract loop over a double-width working register. Each ordinary cycle retires one quotient bit.

The loop looks ahead for stretches that cannot produce a set quotient bit. If the upper 72 bits of the working register are zero and fewer than 56 bits have been retired, eight zero quotient bits go in during one cycle. A small dividend therefore finishes well before the 64-cycle worst case.

Signed requests are handled on magnitudes. The signs are corrected when the loop finishes. A zero divisor does not stall the unit; it returns a fixed result.

Top module: `iter_divider`

## Requirements
- R1: An unsigned full-width quotient request returns floor(dividend / divisor) as a 64-bit value.
- R2: An unsigned full-width remainder request returns dividend mod divisor.
- R3: With the signed flag set, operands are two's complement. The quotient is truncated toward zero and is negated when the operand signs differ. The remainder has the sign of the dividend. The most-negative dividend divided by -1 returns the most-negative value.
- R4: With the half-width flag set, only bits 31:0 of each operand are used. They are sign-extended when signed and zero-extended otherwise. The result is in bits 31:0 and bits 63:32 read zero.
- R5: A zero divisor (judged on the operand width in use) completes normally. It returns zero for a quotient request and the dividend, after the width rule of R4, for a remainder request.
- R6: When the top 72 bits of the 128-bit working register are zero and the retired-bit count is below 56, one cycle retires eight zero quotient bits. Otherwise a cycle retires exactly one bit. A zero dividend therefore completes 15 cycles after the start is accepted.
- R7: The result appears at most 64 cycles after the start is accepted. A dividend of all ones takes exactly 64 cycles.
- R8: `done_o` is a one-cycle pulse that carries the result. `busy_o` is high from the cycle after an accepted start until the cycle in which `done_o` rises, and it is low while `done_o` is high.
- R9: A start pulse that arrives while `busy_o` is high is ignored. The running operation keeps its operands and its timing.
- R10: After reset, `busy_o` and `done_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously |
| start_i | input | 1 | Request pulse, accepted when not busy |
| signed_i | input | 1 | 1: two's complement operands |
| half_i | input | 1 | 1: 32-bit operation on bits 31:0 |
| rem_i | input | 1 | 1: return remainder, 0: return quotient |
| dividend_i | input | 64 | Dividend |
| divisor_i | input | 64 | Divisor |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Single-cycle result strobe |
| result_o | output | 64 | Quotient or remainder, valid with done_o |

## Verification
The bound checker watches four things on every cycle:
- each step advances the retired-bit count by one or by eight, and advances by eight only below 56;
- no request completes more than 64 cycles after acceptance;
- `done_o` is a lone pulse with `busy_o` low;
- the fixed zero-divisor quotient and the clear upper half of 32-bit results hold.

The arithmetic can only be shown by the bench's scenarios. These are a sweep of small signed operands in all eight mode combinations, a grid of corner values and pseudo-random pairs, each compared with an arithmetic model. The scenarios also measure exact latencies for zero and all-ones dividends, and show that a start issued mid-operation is ignored.

// File: rtl/idiv_pkg.sv
package idiv_pkg;

  // Result selection captured at request time and held for the final cycle.
  typedef struct packed {
    logic half;      // 32-bit operation
    logic want_rem;  // remainder instead of quotient
  } idiv_sel_t;

  // Sign corrections captured at request time.
  typedef struct packed {
    logic neg_q;     // negate quotient
    logic neg_r;     // negate remainder
    logic b_zero;    // divisor was zero
  } idiv_fix_t;

endpackage

// File: rtl/idiv_prep.sv
// Operand conditioning: width extension, sign detection, magnitude.
module idiv_prep #(
  parameter int W = 64
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         is_signed_i,
  input  logic         half_i,
  output logic [W-1:0] mag_a_o,
  output logic [W-1:0] mag_b_o,
  output idiv_pkg::idiv_fix_t fix_o
);
  localparam int HALF = W / 2;

  logic [W-1:0] ext_a;
  logic [W-1:0] ext_b;
  logic         sa;
  logic         sb;

  always_comb begin
    if (half_i) begin
      ext_a = {{HALF{is_signed_i & a_i[HALF-1]}}, a_i[HALF-1:0]};
      ext_b = {{HALF{is_signed_i & b_i[HALF-1]}}, b_i[HALF-1:0]};
    end else begin
      ext_a = a_i;
      ext_b = b_i;
    end
    sa = is_signed_i & ext_a[W-1];
    sb = is_signed_i & ext_b[W-1];
    mag_a_o = sa ? (~ext_a + W'(1)) : ext_a;
    mag_b_o = sb ? (~ext_b + W'(1)) : ext_b;
    fix_o.neg_q  = sa ^ sb;
    fix_o.neg_r  = sa;
    fix_o.b_zero = (ext_b == '0);
  end
endmodule

// File: rtl/idiv_step.sv
// One loop iteration: either a single restoring step or a multi-bit zero skip.
module idiv_step #(
  parameter int W      = 64,
  parameter int SKIP_W = 8,
  parameter int CW     = 7
) (
  input  logic [2*W-1:0] acc_i,
  input  logic [W-1:0]   dvsr_i,
  input  logic [CW-1:0]  cnt_i,
  output logic [2*W-1:0] acc_o,
  output logic [CW-1:0]  cnt_o
);
  logic [W:0]     top;      // shifted upper half including the carried-out bit
  logic [W+1:0]   diff;
  logic [2*W-1:0] one_acc;
  logic [CW-1:0]  one_cnt;

  always_comb begin
    top  = acc_i[2*W-1:W-1];
    diff = {1'b0, top} - {2'b00, dvsr_i};
    if (!diff[W+1]) begin
      one_acc = {diff[W-1:0], acc_i[W-2:0], 1'b1};
    end else begin
      one_acc = {acc_i[2*W-2:0], 1'b0};
    end
    one_cnt = cnt_i + CW'(1);
  end

  generate
    if (SKIP_W > 0) begin : g_skip
      logic take_skip;
      always_comb begin
        take_skip = (acc_i[2*W-1:W-SKIP_W] == '0) && (cnt_i < CW'(W - SKIP_W));
        if (take_skip) begin
          acc_o = {acc_i[2*W-1-SKIP_W:0], {SKIP_W{1'b0}}};
          cnt_o = cnt_i + CW'(SKIP_W);
        end else begin
          acc_o = one_acc;
          cnt_o = one_cnt;
        end
      end
    end else begin : g_plain
      always_comb begin
        acc_o = one_acc;
        cnt_o = one_cnt;
      end
    end
  endgenerate
endmodule

// File: rtl/idiv_finish.sv
// Final sign correction, zero-divisor override and result selection.
module idiv_finish #(
  parameter int W = 64
) (
  input  logic [2*W-1:0]          acc_i,
  input  idiv_pkg::idiv_sel_t     sel_i,
  input  idiv_pkg::idiv_fix_t     fix_i,
  output logic [W-1:0]            result_o
);
  localparam int HALF = W / 2;

  logic [W-1:0] q_raw;
  logic [W-1:0] q_s;
  logic [W-1:0] r_s;
  logic [W-1:0] pick;

  always_comb begin
    q_raw = fix_i.b_zero ? '0 : acc_i[W-1:0];
    q_s   = fix_i.neg_q ? (~q_raw + W'(1)) : q_raw;
    r_s   = fix_i.neg_r ? (~acc_i[2*W-1:W] + W'(1)) : acc_i[2*W-1:W];
    pick  = sel_i.want_rem ? r_s : q_s;
    if (sel_i.half) begin
      result_o = {{(W-HALF){1'b0}}, pick[HALF-1:0]};
    end else begin
      result_o = pick;
    end
  end
endmodule

// File: rtl/iter_divider.sv
// Sequential divider: one request at a time, restoring loop with zero-byte skip.
module iter_divider #(
  parameter int DATA_W = 64,
  parameter int SKIP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              signed_i,
  input  logic              half_i,
  input  logic              rem_i,
  input  logic [DATA_W-1:0] dividend_i,
  input  logic [DATA_W-1:0] divisor_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] result_o
);
  import idiv_pkg::*;

  localparam int CW  = $clog2(DATA_W + 1);
  localparam int ACW = 2 * DATA_W;

  // State registers
  logic              busy_q;
  logic              done_q;
  logic [CW-1:0]     cnt_q;
  logic [ACW-1:0]    acc_q;
  logic [DATA_W-1:0] dvsr_q;
  idiv_sel_t         sel_q;
  idiv_fix_t         fix_q;
  logic [DATA_W-1:0] result_q;

  // Next-state values and enables
  logic              busy_d;
  logic              done_d;
  logic [CW-1:0]     cnt_d;
  logic [ACW-1:0]    acc_d;
  logic              load_en;
  logic              run_en;
  logic              res_en;

  // Datapath nets
  logic [DATA_W-1:0] mag_a;
  logic [DATA_W-1:0] mag_b;
  idiv_fix_t         fix_in;
  logic [ACW-1:0]    step_acc;
  logic [CW-1:0]     step_cnt;
  logic [DATA_W-1:0] fin_result;
  idiv_sel_t         sel_in;

  idiv_prep #(.W(DATA_W)) u_prep (
    .a_i         (dividend_i),
    .b_i         (divisor_i),
    .is_signed_i (signed_i),
    .half_i      (half_i),
    .mag_a_o     (mag_a),
    .mag_b_o     (mag_b),
    .fix_o       (fix_in)
  );

  idiv_step #(.W(DATA_W), .SKIP_W(SKIP_W), .CW(CW)) u_step (
    .acc_i  (acc_q),
    .dvsr_i (dvsr_q),
    .cnt_i  (cnt_q),
    .acc_o  (step_acc),
    .cnt_o  (step_cnt)
  );

  idiv_finish #(.W(DATA_W)) u_finish (
    .acc_i    (step_acc),
    .sel_i    (sel_q),
    .fix_i    (fix_q),
    .result_o (fin_result)
  );

  always_comb begin
    sel_in.half     = half_i;
    sel_in.want_rem = rem_i;
  end

  // Next-state logic
  always_comb begin
    busy_d  = busy_q;
    done_d  = 1'b0;
    cnt_d   = cnt_q;
    acc_d   = acc_q;
    load_en = 1'b0;
    run_en  = 1'b0;
    res_en  = 1'b0;
    if (!busy_q) begin
      if (start_i) begin
        load_en = 1'b1;
        busy_d  = 1'b1;
        cnt_d   = '0;
        acc_d   = {{DATA_W{1'b0}}, mag_a};
      end
    end else begin
      run_en = 1'b1;
      acc_d  = step_acc;
      cnt_d  = step_cnt;
      if (step_cnt == CW'(DATA_W)) begin
        busy_d = 1'b0;
        done_d = 1'b1;
        res_en = 1'b1;
      end
    end
  end

  // Control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      if (load_en || run_en) begin
        cnt_q <= cnt_d;
      end
    end
  end

  // Datapath registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q    <= '0;
      dvsr_q   <= '0;
      sel_q    <= '0;
      fix_q    <= '0;
      result_q <= '0;
    end else begin
      if (load_en || run_en) begin
        acc_q <= acc_d;
      end
      if (load_en) begin
        dvsr_q <= mag_b;
        sel_q  <= sel_in;
        fix_q  <= fix_in;
      end
      if (res_en) begin
        result_q <= fin_result;
      end
    end
  end

  assign busy_o   = busy_q;
  assign done_o   = done_q;
  assign result_o = result_q;
endmodule

// File: rtl/iter_divider_checker.sv
module iter_divider_checker #(
  parameter int W      = 64,
  parameter int SKIP_W = 8,
  parameter int CW     = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic          half_i,
  input logic          rem_i,
  input logic [W-1:0]  divisor_i,
  input logic          busy_o,
  input logic          done_o,
  input logic [W-1:0]  result_o,
  input logic [CW-1:0] cnt_q
);
  localparam int HALF = W / 2;

  logic          cap_half;
  logic          cap_rem;
  logic          cap_bz;
  logic [CW:0]   lat_q;
  logic          accept;

  assign accept = start_i && !busy_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_half <= 1'b0;
      cap_rem  <= 1'b0;
      cap_bz   <= 1'b0;
      lat_q    <= '0;
    end else begin
      if (accept) begin
        cap_half <= half_i;
        cap_rem  <= rem_i;
        cap_bz   <= half_i ? (divisor_i[HALF-1:0] == '0) : (divisor_i == '0);
        lat_q    <= '0;
      end else if (busy_o) begin
        lat_q <= lat_q + (CW+1)'(1);
      end
    end
  end

  // R6: every step retires one bit, or eight bits while below the limit
  a_r6_step_size: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |->
      ((cnt_q == $past(cnt_q) + CW'(1)) ||
       ((cnt_q == $past(cnt_q) + CW'(SKIP_W)) && ($past(cnt_q) < CW'(W - SKIP_W)))));

  // R7: completion within the worst-case bound
  a_r7_latency_bound: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (lat_q <= (CW+1)'(W)));

  // R8: done is a lone pulse and busy is low with it
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r8_busy_low_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  // R5: zero divisor quotient is zero
  a_r5_zero_quotient: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && cap_bz && !cap_rem) |-> (result_o == '0));

  // R4: half-width results have a clear upper half
  a_r4_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && cap_half) |-> (result_o[W-1:HALF] == '0));
endmodule

bind iter_divider iter_divider_checker #(
  .W(DATA_W), .SKIP_W(SKIP_W), .CW(CW)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_i   (start_i),
  .half_i    (half_i),
  .rem_i     (rem_i),
  .divisor_i (divisor_i),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .result_o  (result_o),
  .cnt_q     (cnt_q)
);

// File: tb/iter_divider_test.sv
`timescale 1ns/1ps
module iter_divider_test;
  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic        signed_i;
  logic        half_i;
  logic        rem_i;
  logic [63:0] dividend_i;
  logic [63:0] divisor_i;
  logic        busy_o;
  logic        done_o;
  logic [63:0] result_o;

  int n_checks;
  int n_errors;

  iter_divider uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .signed_i   (signed_i),
    .half_i     (half_i),
    .rem_i      (rem_i),
    .dividend_i (dividend_i),
    .divisor_i  (divisor_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .result_o   (result_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] model(input logic [63:0] a, input logic [63:0] b,
                                        input bit sg, input bit hf, input bit rm);
    logic [63:0] ea, eb, ma, mb, q, r, res;
    bit sa, sb;
    ea = hf ? {{32{sg & a[31]}}, a[31:0]} : a;
    eb = hf ? {{32{sg & b[31]}}, b[31:0]} : b;
    sa = sg & ea[63];
    sb = sg & eb[63];
    ma = sa ? -ea : ea;
    mb = sb ? -eb : eb;
    if (mb == 64'd0) begin
      q = 64'd0;
      r = ma;
    end else begin
      q = ma / mb;
      r = ma % mb;
    end
    if (sa ^ sb) q = -q;
    if (sa) r = -r;
    res = rm ? r : q;
    if (hf) res = {32'd0, res[31:0]};
    return res;
  endfunction

  function automatic string tag_for(input logic [63:0] b, input bit sg, input bit hf, input bit rm);
    bit bz;
    bz = hf ? (b[31:0] == 32'd0) : (b == 64'd0);
    if (bz) return "R5 zero divisor";
    if (hf) return "R4 half width";
    if (sg) return "R3 signed";
    if (rm) return "R2 remainder";
    return "R1 quotient";
  endfunction

  // Issue one request; returns result and cycles from acceptance to done.
  task automatic run_op(input logic [63:0] a, input logic [63:0] b,
                        input bit sg, input bit hf, input bit rm,
                        output logic [63:0] res, output int lat);
    @(negedge clk);
    dividend_i = a; divisor_i = b; signed_i = sg; half_i = hf; rem_i = rm;
    start_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    lat = 0;
    while (!done_o && lat < 200) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
    end
    res = result_o;
  endtask

  task automatic do_check(input logic [63:0] a, input logic [63:0] b,
                          input bit sg, input bit hf, input bit rm);
    logic [63:0] res, exp;
    int lat;
    run_op(a, b, sg, hf, rm, res, lat);
    exp = model(a, b, sg, hf, rm);
    check(res === exp, tag_for(b, sg, hf, rm), res, exp);
    check(lat <= 64, "R7 latency bound", 64'(lat), 64'd64);
  endtask

  initial begin
    #(8 * 190000);
    n_errors++;
    n_checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  logic [63:0] corners [9];
  initial begin
    logic [63:0] res;
    logic [63:0] first_exp;
    int lat;
    logic [63:0] seed;
    n_checks = 0;
    n_errors = 0;
    rst_n = 1'b0; start_i = 1'b0; signed_i = 1'b0; half_i = 1'b0; rem_i = 1'b0;
    dividend_i = '0; divisor_i = '0;
    corners[0] = 64'd0;                  corners[1] = 64'd1;
    corners[2] = 64'hFFFF_FFFF_FFFF_FFFF; corners[3] = 64'h8000_0000_0000_0000;
    corners[4] = 64'h7FFF_FFFF_FFFF_FFFF; corners[5] = 64'h0000_0000_8000_0000;
    corners[6] = 64'h0000_0000_FFFF_FFFF; corners[7] = 64'h1234_5678_9ABC_DEF0;
    corners[8] = 64'd7;

    repeat (3) @(negedge clk);
    // R10: reset state
    check(busy_o == 1'b0, "R10 busy after reset", 64'(busy_o), 64'd0);
    check(done_o == 1'b0, "R10 done after reset", 64'(done_o), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy_o == 1'b0 && done_o == 1'b0, "R10 idle after release", 64'(busy_o), 64'd0);

    // R6: zero dividend takes 7 skips then 8 single steps
    run_op(64'd0, 64'd5, 1'b0, 1'b0, 1'b0, res, lat);
    check(lat == 15, "R6 zero dividend latency", 64'(lat), 64'd15);
    check(res == 64'd0, "R6 zero dividend result", res, 64'd0);

    // R7: all-ones dividend gets no skip
    run_op(64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 1'b0, 1'b0, 1'b0, res, lat);
    check(lat == 64, "R7 all-ones latency", 64'(lat), 64'd64);
    check(res == 64'hFFFF_FFFF_FFFF_FFFF, "R1 all-ones by one", res, 64'hFFFF_FFFF_FFFF_FFFF);

    // R8: done is a one-cycle pulse with busy low
    run_op(64'd100, 64'd7, 1'b0, 1'b0, 1'b1, res, lat);
    check(busy_o == 1'b0, "R8 busy low at done", 64'(busy_o), 64'd0);
    check(res == 64'd2, "R2 100 mod 7", res, 64'd2);
    @(negedge clk);
    check(done_o == 1'b0, "R8 done single cycle", 64'(done_o), 64'd0);

    // R9: start while busy is ignored
    @(negedge clk);
    dividend_i = 64'hFFFF_FFFF_FFFF_FFFF; divisor_i = 64'd3;
    signed_i = 1'b0; half_i = 1'b0; rem_i = 1'b0; start_i = 1'b1;
    first_exp = 64'h5555_5555_5555_5555;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    lat = 0;
    repeat (5) begin @(posedge clk); lat++; @(negedge clk); end
    dividend_i = 64'd9; divisor_i = 64'd9; rem_i = 1'b1; start_i = 1'b1;
    @(posedge clk); lat++; @(negedge clk);
    start_i = 1'b0;
    while (!done_o && lat < 200) begin @(posedge clk); lat++; @(negedge clk); end
    check(result_o == first_exp, "R9 ignored start result", result_o, first_exp);
    check(lat == 64, "R9 ignored start timing", 64'(lat), 64'd64);
    @(negedge clk);
    check(busy_o == 1'b0, "R9 no restart after done", 64'(busy_o), 64'd0);

    // Near-exhaustive sweep of small signed operands over all modes
    for (int m = 0; m < 8; m++) begin
      for (int x = -6; x <= 6; x++) begin
        for (int y = -3; y <= 3; y++) begin
          do_check(64'(longint'(x)), 64'(longint'(y)), m[0], m[1], m[2]);
        end
      end
    end

    // Corner grid
    for (int m = 0; m < 8; m++) begin
      for (int i = 0; i < 9; i++) begin
        for (int j = 0; j < 9; j++) begin
          do_check(corners[i], corners[j], m[0], m[1], m[2]);
        end
      end
    end

    // Pseudo-random operands with varied divisor widths
    seed = 64'h9E37_79B9_7F4A_7C15;
    for (int k = 0; k < 160; k++) begin
      logic [63:0] a, b;
      seed = seed ^ (seed << 13); seed = seed ^ (seed >> 7); seed = seed ^ (seed << 17);
      a = seed;
      seed = seed ^ (seed << 13); seed = seed ^ (seed >> 7); seed = seed ^ (seed << 17);
      b = seed >> (k % 60);
      do_check(a, b, k[0], k[1], k[2]);
    end

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule